// File: doc/BRIEF.md
# Banked UART Control Front End

This block is the register front end of a 16550-style serial port, together with the small 8N1 transmit and receive engine it controls. A 4-bit address and 16-bit data bus reach a set of registers. Several of them share an address, and the value held in the line control register decides which one answers. The value 0xBF opens configuration bank B, which holds the feature register and the two divisor bytes. Any other value with bit 7 set opens configuration bank A, which holds the modem control and FIFO control registers. A value with bit 7 clear opens the operational bank, which holds the interrupt enable register and the data port.

Firmware follows a fixed bring-up order. It parks the serial engine through the mode register. It hops between banks to set the feature bit, the FIFO enable and the divisor. It then selects 8N1 operational mode and releases the engine. A soft reset command returns every register to its default and raises a done flag a fixed number of cycles later. Line status reports a waiting received byte and an empty transmit FIFO.

Top module: `banked_uart_ctrl`

## Requirements
- R1: After reset the line control register (address 3) reads 0x00 and the mode register (address 8) reads 7. The reset-done status (address 10, bit 0) reads 1. Line status (address 5) reads 0x20.
- R2: With line control exactly 0xBF, address 0 is the divisor low byte, address 1 the divisor high byte and address 2 the feature register, all readable and writable. Address 4 reads 0.
- R3: With line control bit 7 set and a value other than 0xBF, address 4 is the modem control register. Address 2 is the write-only FIFO control register, which reads 0, and its bit 0 enables the FIFOs. Addresses 0 and 1 read 0.
- R4: With line control bit 7 clear, address 1 is the interrupt enable register and address 0 is the data port. Addresses 2 and 4 read 0 there.
- R5: Interrupt enable bits 7:4 change on a write only while feature bit 4 is 1. Bits 3:0 are always written.
- R6: Address 6 is a trigger-level register that is read and written only while feature bit 4 and modem control bit 6 are both 1. Otherwise it reads 0 and ignores writes.
- R7: Writing a value with bit 1 set to address 9 starts a soft reset. Status bit 0 reads 0 for the next 4 cycles and 1 afterwards, and every register and FIFO returns to its reset value.
- R8: While the mode register is not 0 the serial engine is held off: the line idles at 1 and queued bytes stay in the transmit FIFO. Mode 0 runs the engine.
- R9: Frames are 8N1, least significant bit first. Each bit lasts 16 × divisor clock cycles, where the divisor is {high byte, low byte} and a divisor of 0 counts as 1.
- R10: Line status bit 0 is 1 while a received byte waits. Line status bit 5 is 1 while the transmit FIFO is empty. The other bits read 0.
- R11: A read of the data port in the operational bank returns the oldest received byte and removes exactly that one byte. A write queues one byte for transmission.
- R12: Addresses 7 and 11 to 15 read 0 in every bank and ignore writes.
- R13: With the FIFO enable at 0, each FIFO holds a single byte and further bytes are dropped. With it at 1, each FIFO holds up to FIFO_DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe (pops the receive FIFO at the data port) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data, low byte used |
| bus_rdata | output | 16 | Read data, combinational from the address |
| ser_rxd | input | 1 | Serial receive line |
| ser_txd | output | 1 | Serial transmit line |

## Verification
On every cycle, the assertions check four things: the registers clear while a soft reset runs, the upper interrupt-enable bits stay locked while the feature bit is off, the line idles while the engine is parked, and a data-port read removes exactly one received byte. They also check that unmapped addresses read zero. Only the bench scenarios can show the rest. That covers the bank walk across all three banks, the exact start-bit width for a programmed divisor, and a byte making the round trip from the transmit line back into the receive FIFO. It also covers a second byte being dropped when the FIFOs are disabled.

// File: rtl/bnk_uart_pkg.sv
package bnk_uart_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {BANK_OPER, BANK_CFG_A, BANK_CFG_B} bank_e;

  localparam logic [BYTE_W-1:0] LCR_OPEN_B = 8'hBF;
  localparam logic [2:0]        MODE_OFF   = 3'd7;

  localparam logic [ADDR_W-1:0] A_PORT0 = 4'd0;  // data / divisor low
  localparam logic [ADDR_W-1:0] A_PORT1 = 4'd1;  // irq enable / divisor high
  localparam logic [ADDR_W-1:0] A_PORT2 = 4'd2;  // feature / fifo control
  localparam logic [ADDR_W-1:0] A_LINE  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODEM = 4'd4;
  localparam logic [ADDR_W-1:0] A_LSTAT = 4'd5;
  localparam logic [ADDR_W-1:0] A_TRIG  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd8;
  localparam logic [ADDR_W-1:0] A_SRST  = 4'd9;
  localparam logic [ADDR_W-1:0] A_SSTAT = 4'd10;
endpackage

// File: rtl/bu_fifo.sv
module bu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         deep,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = deep ? (cnt_q == CW'(DEPTH)) : (cnt_q != '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = do_push ? step(wp_q) : wp_q;
    rp_d  = do_pop  ? step(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else if (do_push && !do_pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (do_pop && !do_push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/bu_baud.sv
module bu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick    = run && (cnt_q >= div_eff - 1'b1);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bu_tx.sv
module bu_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          have,
  input  logic [DW-1:0] din,
  output logic          take,
  output logic          txd
);
  localparam int FW = DW + 2;
  localparam int BW = $clog2(FW);
  localparam int TW = $clog2(OSR);

  logic          busy_q, busy_d, txd_q, txd_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [TW-1:0] tc_q, tc_d;

  always_comb begin
    busy_d = busy_q;
    txd_d  = txd_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    tc_d   = tc_q;
    take   = 1'b0;
    if (!run) begin
      busy_d = 1'b0;
      txd_d  = 1'b1;
      bit_d  = '0;
      tc_d   = '0;
    end else if (tick) begin
      if (!busy_q) begin
        if (have) begin
          take   = 1'b1;
          sh_d   = {1'b1, din, 1'b0};
          txd_d  = 1'b0;
          busy_d = 1'b1;
          bit_d  = '0;
          tc_d   = '0;
        end
      end else if (tc_q == TW'(OSR-1)) begin
        tc_d = '0;
        if (bit_q == BW'(FW-1)) begin
          busy_d = 1'b0;
          txd_d  = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = sh_q >> 1;
          txd_d = sh_q[1];
        end
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '0;
      bit_q  <= '0;
      tc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      txd_q  <= txd_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      tc_q   <= tc_d;
    end
  end

  assign txd = txd_q;
endmodule

// File: rtl/bu_rx.sv
module bu_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          rxd,
  output logic          push,
  output logic [DW-1:0] dout
);
  localparam int FW  = DW + 2;
  localparam int BW  = $clog2(FW);
  localparam int TW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  logic          s1_q, s2_q, act_q, act_d, push_q, push_d;
  logic [TW-1:0] tc_q, tc_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d, dq_q, dq_d;

  always_comb begin
    act_d  = act_q;
    tc_d   = tc_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    dq_d   = dq_q;
    push_d = 1'b0;
    if (!run) begin
      act_d = 1'b0;
    end else if (tick) begin
      if (!act_q) begin
        if (!s2_q) begin
          act_d = 1'b1;
          tc_d  = '0;
          bit_d = '0;
        end
      end else begin
        tc_d = (tc_q == TW'(OSR-1)) ? '0 : tc_q + 1'b1;
        if (tc_q == TW'(OSR-1)) bit_d = bit_q + 1'b1;
        if (tc_q == TW'(MID)) begin
          if (bit_q == '0) begin
            if (s2_q) act_d = 1'b0;
          end else if (bit_q == BW'(FW-1)) begin
            act_d = 1'b0;
            if (s2_q) begin
              push_d = 1'b1;
              dq_d   = sh_q;
            end
          end else begin
            sh_d = {s2_q, sh_q[DW-1:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      act_q  <= 1'b0;
      tc_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      dq_q   <= '0;
      push_q <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      act_q  <= act_d;
      tc_q   <= tc_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      dq_q   <= dq_d;
      push_q <= push_d;
    end
  end

  assign push = push_q;
  assign dout = dq_q;
endmodule

// File: rtl/bu_regs.sv
module bu_regs
  import bnk_uart_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic              tx_empty,
  output logic              tx_push,
  output logic              rx_pop,
  output logic [15:0]       divisor,
  output logic              fifo_en,
  output logic              engine_on,
  output logic              soft_busy,
  output logic [BYTE_W-1:0] lcr,
  output logic [BYTE_W-1:0] ier,
  output logic [BYTE_W-1:0] efr,
  output logic [2:0]        mode
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [BYTE_W-1:0] lcr_q, lcr_d, ier_q, ier_d, efr_q, efr_d, mcr_q, mcr_d;
  logic [BYTE_W-1:0] dll_q, dll_d, dlh_q, dlh_d, tlr_q, tlr_d;
  logic              fcr_q, fcr_d;
  logic [2:0]        mdr_q, mdr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  bank_e             bank;
  logic              trig_ok, busy, acc_ok;
  logic [BYTE_W-1:0] wb, rb;
  logic              unused_hi;

  assign wb        = wdata[BYTE_W-1:0];
  assign unused_hi = ^wdata[BUS_W-1:BYTE_W];
  assign busy      = (cnt_q != '0);
  assign acc_ok    = !busy;
  assign trig_ok   = efr_q[4] & mcr_q[6];

  always_comb begin
    if (lcr_q == LCR_OPEN_B) bank = BANK_CFG_B;
    else if (lcr_q[7])       bank = BANK_CFG_A;
    else                     bank = BANK_OPER;
  end

  always_comb begin
    lcr_d = lcr_q; ier_d = ier_q; efr_d = efr_q; mcr_d = mcr_q;
    dll_d = dll_q; dlh_d = dlh_q; tlr_d = tlr_q; fcr_d = fcr_q;
    mdr_d = mdr_q; cnt_d = cnt_q;
    if (busy) begin
      lcr_d = '0; ier_d = '0; efr_d = '0; mcr_d = '0;
      dll_d = '0; dlh_d = '0; tlr_d = '0; fcr_d = 1'b0;
      mdr_d = MODE_OFF;
      cnt_d = cnt_q - 1'b1;
    end else if (wr) begin
      case (addr)
        A_LINE:  lcr_d = wb;
        A_MODE:  mdr_d = wb[2:0];
        A_SRST:  if (wb[1]) cnt_d = CW'(RST_CYCLES);
        A_TRIG:  if (trig_ok) tlr_d = wb;
        A_PORT0: if (bank == BANK_CFG_B) dll_d = wb;
        A_PORT1: begin
          if (bank == BANK_CFG_B)     dlh_d = wb;
          else if (bank == BANK_OPER) ier_d = efr_q[4] ? wb : {ier_q[7:4], wb[3:0]};
        end
        A_PORT2: begin
          if (bank == BANK_CFG_B)      efr_d = wb;
          else if (bank == BANK_CFG_A) fcr_d = wb[0];
        end
        A_MODEM: if (bank == BANK_CFG_A) mcr_d = wb;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0; ier_q <= '0; efr_q <= '0; mcr_q <= '0;
      dll_q <= '0; dlh_q <= '0; tlr_q <= '0; fcr_q <= 1'b0;
      mdr_q <= MODE_OFF; cnt_q <= '0;
    end else begin
      lcr_q <= lcr_d; ier_q <= ier_d; efr_q <= efr_d; mcr_q <= mcr_d;
      dll_q <= dll_d; dlh_q <= dlh_d; tlr_q <= tlr_d; fcr_q <= fcr_d;
      mdr_q <= mdr_d; cnt_q <= cnt_d;
    end
  end

  always_comb begin
    rb = '0;
    case (addr)
      A_PORT0: if (bank == BANK_OPER) rb = rx_head;
               else if (bank == BANK_CFG_B) rb = dll_q;
      A_PORT1: if (bank == BANK_OPER) rb = ier_q;
               else if (bank == BANK_CFG_B) rb = dlh_q;
      A_PORT2: if (bank == BANK_CFG_B) rb = efr_q;
      A_LINE:  rb = lcr_q;
      A_MODEM: if (bank == BANK_CFG_A) rb = mcr_q;
      A_LSTAT: rb = {2'b00, tx_empty, 4'b0000, ~rx_empty};
      A_TRIG:  if (trig_ok) rb = tlr_q;
      A_MODE:  rb = {5'b0, mdr_q};
      A_SSTAT: rb = {7'b0, ~busy};
      default: rb = '0;
    endcase
  end

  assign rdata     = {{(BUS_W-BYTE_W){1'b0}}, rb};
  assign tx_push   = wr & acc_ok & (addr == A_PORT0) & (bank == BANK_OPER);
  assign rx_pop    = rd & acc_ok & (addr == A_PORT0) & (bank == BANK_OPER) & ~rx_empty;
  assign divisor   = {dlh_q, dll_q};
  assign fifo_en   = fcr_q;
  assign engine_on = (mdr_q == 3'd0);
  assign soft_busy = busy;
  assign lcr       = lcr_q;
  assign ier       = ier_q;
  assign efr       = efr_q;
  assign mode      = mdr_q;
endmodule

// File: rtl/banked_uart_ctrl.sv
module banked_uart_ctrl
  import bnk_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RST_CYCLES = 4,
  parameter int OSR        = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        ser_rxd,
  output logic        ser_txd
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              rs1_q, rs2_q, rst_i;
  logic              tx_push, rx_pop, fifo_en, engine_on, soft_busy, tick;
  logic [15:0]       divisor;
  logic [BYTE_W-1:0] lcr_q, ier_q, efr_q, rx_head, tx_head, rx_byte;
  logic [2:0]        mdr_q;
  logic              tx_empty, tx_full, rx_empty, rx_full, tx_take, rx_push;
  logic [CNT_W-1:0]  tx_count, rx_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  bu_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .rx_head(rx_head),
    .rx_empty(rx_empty), .tx_empty(tx_empty), .tx_push(tx_push),
    .rx_pop(rx_pop), .divisor(divisor), .fifo_en(fifo_en),
    .engine_on(engine_on), .soft_busy(soft_busy), .lcr(lcr_q),
    .ier(ier_q), .efr(efr_q), .mode(mdr_q)
  );

  bu_baud #(.DIV_W(16)) u_baud (
    .clk(clk), .rst_n(rst_i), .run(engine_on), .divisor(divisor), .tick(tick)
  );

  bu_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .clr(soft_busy), .deep(fifo_en),
    .push(tx_push), .din(bus_wdata[BYTE_W-1:0]), .pop(tx_take),
    .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  bu_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .clr(soft_busy), .deep(fifo_en),
    .push(rx_push), .din(rx_byte), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  bu_tx #(.DW(BYTE_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_i), .run(engine_on), .tick(tick),
    .have(~tx_empty), .din(tx_head), .take(tx_take), .txd(ser_txd)
  );

  bu_rx #(.DW(BYTE_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_i), .run(engine_on), .tick(tick),
    .rxd(ser_rxd), .push(rx_push), .dout(rx_byte)
  );

  logic unused_top;
  assign unused_top = ^{tx_full, rx_full, tx_count, lcr_q, ier_q, efr_q, mdr_q};
endmodule

// File: rtl/banked_uart_ctrl_chk.sv
module banked_uart_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    addr,
  input logic [15:0]   rdata,
  input logic          txd,
  input logic          soft_busy,
  input logic [7:0]    lcr,
  input logic [7:0]    ier,
  input logic [7:0]    efr,
  input logic [2:0]    mode,
  input logic          rx_pop,
  input logic          rx_push,
  input logic [CW-1:0] rx_count
);
  assert_clear_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_busy |=> (lcr == 8'h00 && mode == 3'd7));

  assert_ier_high_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!efr[4] && !soft_busy) |=> $stable(ier[7:4]));

  assert_line_idle_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0) |=> txd);

  assert_pop_removes_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push) |=> ((rx_count + CW'(1)) == $past(rx_count)));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd7 || addr > 4'd10) |-> (rdata == 16'h0000));
endmodule

bind banked_uart_ctrl banked_uart_ctrl_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rdata(bus_rdata),
  .txd(ser_txd), .soft_busy(soft_busy), .lcr(lcr_q), .ier(ier_q),
  .efr(efr_q), .mode(mdr_q), .rx_pop(rx_pop), .rx_push(rx_push),
  .rx_count(rx_count)
);

// File: tb/banked_uart_ctrl_tb.sv
module banked_uart_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ser_txd;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  banked_uart_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_rxd(ser_txd), .ser_txd(ser_txd)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd3,  8'h00, 8'd1},  // R1 line control default
    '{1'b0, 4'd8,  8'h07, 8'd1},  // R1 mode parked
    '{1'b0, 4'd10, 8'h01, 8'd1},  // R1 reset done
    '{1'b0, 4'd5,  8'h20, 8'd1},  // R1 line status
    '{1'b1, 4'd1,  8'hFF, 8'd5},  // R5 feature bit off
    '{1'b0, 4'd1,  8'h0F, 8'd5},
    '{1'b1, 4'd7,  8'h55, 8'd12}, // R12 unmapped
    '{1'b0, 4'd7,  8'h00, 8'd12},
    '{1'b0, 4'd15, 8'h00, 8'd12},
    '{1'b0, 4'd2,  8'h00, 8'd4},  // R4 op bank hides feature reg
    '{1'b0, 4'd4,  8'h00, 8'd4},
    '{1'b1, 4'd3,  8'hBF, 8'd2},  // R2 bank B
    '{1'b0, 4'd3,  8'hBF, 8'd2},
    '{1'b1, 4'd2,  8'h10, 8'd2},
    '{1'b0, 4'd2,  8'h10, 8'd2},
    '{1'b1, 4'd0,  8'h34, 8'd2},
    '{1'b0, 4'd0,  8'h34, 8'd2},
    '{1'b1, 4'd1,  8'h12, 8'd2},
    '{1'b0, 4'd1,  8'h12, 8'd2},
    '{1'b0, 4'd4,  8'h00, 8'd2},
    '{1'b1, 4'd3,  8'h80, 8'd3},  // R3 bank A
    '{1'b0, 4'd0,  8'h00, 8'd3},
    '{1'b0, 4'd1,  8'h00, 8'd3},
    '{1'b1, 4'd4,  8'h40, 8'd3},
    '{1'b0, 4'd4,  8'h40, 8'd3},
    '{1'b0, 4'd2,  8'h00, 8'd3},
    '{1'b1, 4'd6,  8'h3C, 8'd6},  // R6 trigger level open
    '{1'b0, 4'd6,  8'h3C, 8'd6},
    '{1'b1, 4'd3,  8'h00, 8'd4},  // R4 back to op bank
    '{1'b1, 4'd1,  8'hF3, 8'd5},  // R5 feature bit on
    '{1'b0, 4'd1,  8'hF3, 8'd5},
    '{1'b1, 4'd3,  8'h80, 8'd6},  // R6 close trigger level
    '{1'b1, 4'd4,  8'h00, 8'd6},
    '{1'b0, 4'd6,  8'h00, 8'd6},
    '{1'b1, 4'd6,  8'h77, 8'd6},
    '{1'b1, 4'd4,  8'h40, 8'd6},
    '{1'b0, 4'd6,  8'h3C, 8'd6},
    '{1'b1, 4'd3,  8'h03, 8'd4},
    '{1'b0, 4'd3,  8'h03, 8'd4}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = {8'h00, d}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] e);
    logic [15:0] v;
    do_rd(a, v);
    chk(tag, v, {8'h00, e});
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    bit          seen;
    int          lo, waited;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_wr(VECS[i].a, VECS[i].d);
      else rd_chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].a, VECS[i].d);
    end

    // R7 soft reset: done flag low for four cycles, then registers at defaults
    do_wr(4'd9, 8'h02);
    for (int i = 0; i < 4; i++) rd_chk("R7 done low", 4'd10, 8'h00);
    rd_chk("R7 done high", 4'd10, 8'h01);
    rd_chk("R7 lcr", 4'd3, 8'h00);
    rd_chk("R7 mode", 4'd8, 8'h07);
    rd_chk("R7 ier", 4'd1, 8'h00);
    do_wr(4'd3, 8'hBF);
    rd_chk("R7 dll", 4'd0, 8'h00);
    rd_chk("R7 dlh", 4'd1, 8'h00);
    rd_chk("R7 efr", 4'd2, 8'h00);

    // R9 program divisor 2, enable FIFOs, 8N1 operational bank
    do_wr(4'd0, 8'h02);
    do_wr(4'd1, 8'h00);
    do_wr(4'd3, 8'h80);
    do_wr(4'd2, 8'h01);
    do_wr(4'd3, 8'h03);
    do_wr(4'd0, 8'hA5);
    // R8 parked engine keeps the byte and the idle line
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (ser_txd !== 1'b1) seen = 1'b1;
      @(negedge clk);
    end
    chk("R8 line idle while parked", {15'b0, seen}, 16'h0000);
    rd_chk("R8 R10 byte held", 4'd5, 8'h00);
    do_wr(4'd8, 8'h00);
    waited = 0;
    while (ser_txd === 1'b1 && waited < 400) begin waited++; @(negedge clk); end
    lo = 0;
    while (ser_txd === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
    chk("R9 start bit cycles", 16'(lo), 16'd32);
    seen = 1'b0;
    for (int i = 0; i < 1000 && !seen; i++) begin
      do_rd(4'd5, v);
      if (v[0]) seen = 1'b1;
    end
    rd_chk("R10 rx waiting tx empty", 4'd5, 8'h21);
    rd_chk("R11 R9 loopback byte", 4'd0, 8'hA5);
    rd_chk("R11 single pop", 4'd5, 8'h20);

    // R13 FIFOs disabled: second byte dropped
    do_wr(4'd8, 8'h07);
    do_wr(4'd3, 8'h80);
    do_wr(4'd2, 8'h00);
    do_wr(4'd3, 8'h03);
    do_wr(4'd0, 8'h11);
    do_wr(4'd0, 8'h22);
    do_wr(4'd8, 8'h00);
    repeat (900) @(negedge clk);
    rd_chk("R13 shallow one byte", 4'd5, 8'h21);
    rd_chk("R13 shallow data", 4'd0, 8'h11);
    rd_chk("R13 shallow drop", 4'd5, 8'h20);

    // R13 FIFOs enabled: three bytes in order
    do_wr(4'd8, 8'h07);
    do_wr(4'd3, 8'h80);
    do_wr(4'd2, 8'h01);
    do_wr(4'd3, 8'h03);
    do_wr(4'd0, 8'hC3);
    do_wr(4'd0, 8'h3C);
    do_wr(4'd0, 8'h5A);
    do_wr(4'd8, 8'h00);
    repeat (1300) @(negedge clk);
    rd_chk("R13 deep byte0", 4'd0, 8'hC3);
    rd_chk("R13 deep byte1", 4'd0, 8'h3C);
    rd_chk("R13 deep byte2", 4'd0, 8'h5A);
    rd_chk("R13 R10 drained", 4'd5, 8'h20);

    done = 1'b1;
    summary();
  end
endmodule